// File: doc/BRIEF.md
# Self-Clearing Soft Reset Controller

This block holds the reset-request register of a two-clock USB-style controller. It runs on a bus clock and a PHY clock. Software writes ones into the register to ask for one of four actions: a soft reset of the whole controller, a reset of the full-speed protocol engine, a reset of the frame number counter, or a flush of the receive FIFO. Each action is sent into the PHY clock domain over a toggle handshake with two-flop synchronizers. The request bit stays set until the acknowledge toggle has come back into the bus domain, and then it clears itself. Software polls the bit to learn when the action is done.

A whole-controller reset first asks the bus master to stop, and waits until the master reports that it is idle. The master is expected to stop only after it has finished its current data phase. The block then gives one bus-clock pulse that clears the interrupt and configuration state and empties the FIFOs. Three configuration fields are kept through this reset. In the same reset, a pulse goes to the PHY side, which stops USB activity at once and zeroes the frame counter. The frame number counter lives in the PHY domain: it counts start-of-frame strobes, and its reset makes the next frame number 0.

Bit 31 of the register shows whether the bus master is idle. After the whole-controller bit clears, software must wait at least 3 PHY clocks before it touches the PHY domain.

Top module: `usb_softrst_ctrl`

The whole-reset sequencer has four states:
- `GS_IDLE`, waiting. It moves to `GS_DRAIN` on a new request.
- `GS_DRAIN`, master asked to stop. It moves to `GS_CLEAR` once the master reports idle.
- `GS_CLEAR`, a one-cycle clear, which also starts the PHY handshake. It always moves to `GS_PHY`.
- `GS_PHY`, waiting for the acknowledge. It returns to `GS_IDLE` when the acknowledge arrives.

Each handshake channel has two small state machines:
- Bus side: `BS_IDLE` moves to `BS_WAIT` on a start. `BS_WAIT` returns to `BS_IDLE` once the acknowledge matches and the minimum bus-cycle count has passed.
- PHY side: `PS_IDLE` moves to `PS_ACT` when it sees a new request toggle. `PS_ACT` returns to `PS_IDLE` after the hold count and toggles the acknowledge on the way.

## Requirements
- R1: Request bits 0 (whole reset), 1 (engine reset), 2 (frame counter reset) and 4 (receive flush) are write-1-to-set. Writing 0 to a bit has no effect. A set bit reads 1 until its action has been acknowledged, and then reads 0 with no software write.
- R2: Bit 3 and bits 30:5 always read 0, and writes to them are ignored.
- R3: Bit 31 reads the current level of `mst_idle_i`.
- R4: While bit 0 is pending, `mst_stop_o` is high until `mst_idle_i` is seen high. `core_rst_o` is a single bus-clock pulse that comes only after `mst_idle_i` has been seen high, once per whole reset.
- R5: On `core_rst_o`, `irq_o` becomes 0 and every configuration bit outside the kept mask becomes 0. The kept bits hold their value: [1:0] host PHY speed, [3:2] device speed, [4] device soft disconnect.
- R6: A whole reset raises `phy_core_rst_o` for `GLB_HOLD` PHY clocks (2 by default). Bit 0 clears only after that pulse has been acknowledged.
- R7: An engine reset (bit 1) raises `fs_rst_o` for exactly one PHY clock per request. Bit 1 then clears.
- R8: `frame_num_o` is the number the next start-of-frame will carry. Each `sof_i` strobe adds 1 to it (modulo 2^FRAME_W). It becomes 0 on a frame counter reset (bit 2) or a whole reset, so it reads 0 when the bit has cleared.
- R9: A receive flush (bit 4) holds `rxflush_o` high for exactly `FLUSH_CYC` PHY clocks (8 by default). Bit 4 clears no sooner than `FLUSH_CYC` periods of the slower of the two clocks after it was set.
- R10: Requests on different bits proceed independently. When several bits are written in one access, each action takes place and each bit clears on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Bus-domain asynchronous reset, active low |
| phy_clk_i | input | 1 | PHY clock |
| phy_rst_ni | input | 1 | PHY-domain asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the reset register |
| reg_wdata_i | input | 32 | Write data for the reset register |
| reg_rdata_o | output | 32 | Reset register read value |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| cfg_o | output | CFG_W | Current configuration word |
| irq_set_i | input | IRQ_W | Interrupt set strobes, one per source |
| irq_o | output | IRQ_W | Pending interrupt flags |
| mst_idle_i | input | 1 | Bus master reports no transfer in progress |
| mst_stop_o | output | 1 | Asks the bus master to stop at its next data-phase boundary |
| core_rst_o | output | 1 | Bus-domain reset pulse for state machines and FIFOs |
| phy_core_rst_o | output | 1 | PHY-domain whole-reset pulse |
| fs_rst_o | output | 1 | PHY-domain full-speed engine reset pulse |
| rxflush_o | output | 1 | PHY-domain receive FIFO flush level |
| sof_i | input | 1 | PHY-domain start-of-frame strobe |
| frame_num_o | output | FRAME_W | Frame number for the next start-of-frame |

## Verification
The bench builds the block with its default parameters: a flush length of 8, a whole-reset hold of 2, two synchronizer stages and a kept mask of 0x1F on a 16-bit configuration word. These settings let the flush window be counted cycle by cycle on the PHY side. The bench changes the PHY clock period while the run is going on, so that it is first slower and then faster than the bus clock. This checks the "slower of the two clocks" lower bound from both sides. Random configuration words, interrupt patterns, frame strobe counts and request mixes show that the kept fields survive a whole reset and that the frame number comes back to zero.

// File: rtl/usb_rst_pkg.sv
package usb_rst_pkg;

    localparam int unsigned RB_GLB  = 0;
    localparam int unsigned RB_FSR  = 1;
    localparam int unsigned RB_FRM  = 2;
    localparam int unsigned RB_RXF  = 4;
    localparam int unsigned RB_IDLE = 31;

    typedef enum logic {
        BS_IDLE,
        BS_WAIT
    } bside_e;

    typedef enum logic {
        PS_IDLE,
        PS_ACT
    } pside_e;

    typedef enum logic [1:0] {
        GS_IDLE,
        GS_DRAIN,
        GS_CLEAR,
        GS_PHY
    } gseq_e;

endpackage

// File: rtl/usb_rst_sync.sv
module usb_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/usb_rst_chan.sv
// One request channel: a toggle goes from the bus domain to the PHY domain,
// the PHY side holds its action for HOLD_CYC cycles, and then an acknowledge
// toggle comes back. done_o fires once both the acknowledge has arrived and
// MIN_BUS bus cycles have passed.
module usb_rst_chan
    import usb_rst_pkg::*;
#(
    parameter int unsigned HOLD_CYC    = 1,
    parameter int unsigned MIN_BUS     = 0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic done_o,
    input  logic phy_clk_i,
    input  logic phy_rst_ni,
    output logic act_o
);

    localparam int unsigned CW = $clog2(MIN_BUS + 2);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);

    // ---------------- bus side ----------------
    bside_e         bs_q, bs_d;
    logic           req_tg_q;
    logic [CW-1:0]  bcnt_q;
    logic           ack_s;
    logic           cnt_ok;
    logic           ack_match;

    assign ack_match = (ack_s == req_tg_q);

    if (MIN_BUS == 0) begin : g_nomin
        logic unused_bcnt;
        assign unused_bcnt = ^bcnt_q;
        assign cnt_ok = 1'b1;
    end else begin : g_min
        assign cnt_ok = (bcnt_q >= CW'(MIN_BUS));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bs_q <= BS_IDLE;
        end else begin
            bs_q <= bs_d;
        end
    end

    always_comb begin
        bs_d = bs_q;
        unique case (bs_q)
            BS_IDLE: if (start_i) bs_d = BS_WAIT;
            BS_WAIT: if (ack_match && cnt_ok) bs_d = BS_IDLE;
            default: bs_d = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_tg_q <= 1'b0;
            bcnt_q   <= '0;
        end else if (bs_q == BS_IDLE) begin
            if (start_i) begin
                req_tg_q <= ~req_tg_q;
                bcnt_q   <= '0;
            end
        end else if (bcnt_q != CW'(MIN_BUS)) begin
            bcnt_q <= bcnt_q + CW'(1);
        end
    end

    always_comb begin
        done_o = (bs_q == BS_WAIT) && ack_match && cnt_ok;
    end

    // ---------------- PHY side ----------------
    pside_e         ps_q, ps_d;
    logic           req_s;
    logic           req_seen_q;
    logic           ack_tg_q;
    logic [HW-1:0]  hcnt_q;
    logic           hold_last;

    usb_rst_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk_i  (phy_clk_i),
        .rst_ni (phy_rst_ni),
        .d_i    (req_tg_q),
        .q_o    (req_s)
    );

    assign hold_last = (hcnt_q == HW'(HOLD_CYC - 1));

    always_ff @(posedge phy_clk_i or negedge phy_rst_ni) begin
        if (!phy_rst_ni) begin
            ps_q <= PS_IDLE;
        end else begin
            ps_q <= ps_d;
        end
    end

    always_comb begin
        ps_d = ps_q;
        unique case (ps_q)
            PS_IDLE: if (req_s != req_seen_q) ps_d = PS_ACT;
            PS_ACT:  if (hold_last) ps_d = PS_IDLE;
            default: ps_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge phy_clk_i or negedge phy_rst_ni) begin
        if (!phy_rst_ni) begin
            req_seen_q <= 1'b0;
            ack_tg_q   <= 1'b0;
            hcnt_q     <= '0;
        end else if (ps_q == PS_IDLE) begin
            if (req_s != req_seen_q) begin
                req_seen_q <= req_s;
                hcnt_q     <= '0;
            end
        end else begin
            hcnt_q <= hcnt_q + HW'(1);
            if (hold_last) begin
                ack_tg_q <= ~ack_tg_q;
            end
        end
    end

    always_comb begin
        act_o = (ps_q == PS_ACT);
    end

    usb_rst_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (ack_tg_q),
        .q_o    (ack_s)
    );

endmodule

// File: rtl/usb_rst_gseq.sv
// Whole-controller reset sequencer: drain the bus master, clear, then
// wait for the PHY-side acknowledge.
module usb_rst_gseq
    import usb_rst_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic mst_idle_i,
    input  logic chan_done_i,
    output logic mst_stop_o,
    output logic core_rst_o,
    output logic chan_start_o,
    output logic done_o
);

    gseq_e st_q, st_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= GS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GS_IDLE:  if (start_i) st_d = GS_DRAIN;
            GS_DRAIN: if (mst_idle_i) st_d = GS_CLEAR;
            GS_CLEAR: st_d = GS_PHY;
            GS_PHY:   if (chan_done_i) st_d = GS_IDLE;
            default:  st_d = GS_IDLE;
        endcase
    end

    always_comb begin
        mst_stop_o   = (st_q == GS_DRAIN);
        core_rst_o   = (st_q == GS_CLEAR);
        chan_start_o = (st_q == GS_CLEAR);
        done_o       = (st_q == GS_PHY) && chan_done_i;
    end

endmodule

// File: rtl/usb_softrst_ctrl.sv
module usb_softrst_ctrl
    import usb_rst_pkg::*;
#(
    parameter int unsigned            CFG_W       = 16,
    parameter logic [CFG_W-1:0]       KEEP_MASK   = 'h1F,
    parameter int unsigned            IRQ_W       = 8,
    parameter int unsigned            FRAME_W     = 11,
    parameter int unsigned            FLUSH_CYC   = 8,
    parameter int unsigned            GLB_HOLD    = 2,
    parameter int unsigned            SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               phy_clk_i,
    input  logic               phy_rst_ni,
    input  logic               reg_we_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    input  logic               cfg_we_i,
    input  logic [CFG_W-1:0]   cfg_wdata_i,
    output logic [CFG_W-1:0]   cfg_o,
    input  logic [IRQ_W-1:0]   irq_set_i,
    output logic [IRQ_W-1:0]   irq_o,
    input  logic               mst_idle_i,
    output logic               mst_stop_o,
    output logic               core_rst_o,
    output logic               phy_core_rst_o,
    output logic               fs_rst_o,
    output logic               rxflush_o,
    input  logic               sof_i,
    output logic [FRAME_W-1:0] frame_num_o
);

    // Channel order: 0 whole reset, 1 engine reset, 2 frame reset, 3 flush.
    localparam int unsigned NCH = 4;
    localparam int unsigned CH_BIT [NCH] = '{RB_GLB, RB_FSR, RB_FRM, RB_RXF};

    logic [NCH-1:0] req_q;
    logic [NCH-1:0] set_req;
    logic [NCH-1:0] chan_start;
    logic [NCH-1:0] chan_done;
    logic [NCH-1:0] chan_act;
    logic [NCH-1:0] clr_req;
    logic           g_start;
    logic           g_done;

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata_i[31:5], reg_wdata_i[3]};

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            set_req[i] = reg_we_i && reg_wdata_i[CH_BIT[i]] && !req_q[i];
        end
        chan_start    = set_req;
        chan_start[0] = g_start;
        clr_req       = chan_done;
        clr_req[0]    = g_done;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_q <= '0;
        end else begin
            req_q <= (req_q | set_req) & ~clr_req;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        for (int i = 0; i < NCH; i++) begin
            reg_rdata_o[CH_BIT[i]] = req_q[i];
        end
        reg_rdata_o[RB_IDLE] = mst_idle_i;
    end

    usb_rst_gseq u_gseq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (set_req[0]),
        .mst_idle_i   (mst_idle_i),
        .chan_done_i  (chan_done[0]),
        .mst_stop_o   (mst_stop_o),
        .core_rst_o   (core_rst_o),
        .chan_start_o (g_start),
        .done_o       (g_done)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        usb_rst_chan #(
            .HOLD_CYC    ((g == 3) ? FLUSH_CYC : ((g == 0) ? GLB_HOLD : 1)),
            .MIN_BUS     ((g == 3) ? FLUSH_CYC : 0),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_chan (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .start_i    (chan_start[g]),
            .done_o     (chan_done[g]),
            .phy_clk_i  (phy_clk_i),
            .phy_rst_ni (phy_rst_ni),
            .act_o      (chan_act[g])
        );
    end

    // Configuration and interrupt state; the clear pulse has priority.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_o <= '0;
            irq_o <= '0;
        end else if (core_rst_o) begin
            cfg_o <= cfg_o & KEEP_MASK;
            irq_o <= '0;
        end else begin
            if (cfg_we_i) begin
                cfg_o <= cfg_wdata_i;
            end
            irq_o <= irq_o | irq_set_i;
        end
    end

    // PHY-domain frame number: value that the next start-of-frame carries.
    always_ff @(posedge phy_clk_i or negedge phy_rst_ni) begin
        if (!phy_rst_ni) begin
            frame_num_o <= '0;
        end else if (chan_act[0] || chan_act[2]) begin
            frame_num_o <= '0;
        end else if (sof_i) begin
            frame_num_o <= frame_num_o + FRAME_W'(1);
        end
    end

    assign phy_core_rst_o = chan_act[0];
    assign fs_rst_o       = chan_act[1];
    assign rxflush_o      = chan_act[3];

endmodule

// File: rtl/usb_softrst_ctrl_chk.sv
module usb_softrst_ctrl_chk #(
    parameter int unsigned      CFG_W     = 16,
    parameter logic [CFG_W-1:0] KEEP_MASK = 'h1F,
    parameter int unsigned      IRQ_W     = 8,
    parameter int unsigned      FRAME_W   = 11
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               phy_clk_i,
    input logic               phy_rst_ni,
    input logic               reg_we_i,
    input logic               wr_fsr,
    input logic               req_glb,
    input logic               req_fsr,
    input logic               rsv_bit,
    input logic [CFG_W-1:0]   cfg_o,
    input logic [IRQ_W-1:0]   irq_o,
    input logic               core_rst_o,
    input logic               mst_idle_i,
    input logic               mst_stop_o,
    input logic [FRAME_W-1:0] frame_num_o
);

    // R1
    zero_write_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && !wr_fsr && !req_fsr) |=> !req_fsr);

    // R2
    rsv_bit_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_we_i |=> !rsv_bit);

    // R4
    stop_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mst_stop_o |-> req_glb);

    // R4
    clear_after_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_rst_o |-> $past(mst_idle_i));

    // R4
    clear_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_rst_o |=> !core_rst_o);

    // R5
    keep_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_rst_o |=> (cfg_o == ($past(cfg_o) & KEEP_MASK)));

    // R5
    irq_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_rst_o |=> (irq_o == '0));

    // R8
    frame_step_chk: assert property (@(posedge phy_clk_i) disable iff (!phy_rst_ni)
        !$stable(frame_num_o) |->
            ((frame_num_o == '0) || (frame_num_o == $past(frame_num_o) + FRAME_W'(1))));

endmodule

bind usb_softrst_ctrl usb_softrst_ctrl_chk #(
    .CFG_W     (CFG_W),
    .KEEP_MASK (KEEP_MASK),
    .IRQ_W     (IRQ_W),
    .FRAME_W   (FRAME_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phy_clk_i   (phy_clk_i),
    .phy_rst_ni  (phy_rst_ni),
    .reg_we_i    (reg_we_i),
    .wr_fsr      (reg_wdata_i[1]),
    .req_glb     (reg_rdata_o[0]),
    .req_fsr     (reg_rdata_o[1]),
    .rsv_bit     (reg_rdata_o[3]),
    .cfg_o       (cfg_o),
    .irq_o       (irq_o),
    .core_rst_o  (core_rst_o),
    .mst_idle_i  (mst_idle_i),
    .mst_stop_o  (mst_stop_o),
    .frame_num_o (frame_num_o)
);

// File: tb/tb_usb_softrst_ctrl.sv
`timescale 1ns/1ps
module tb_usb_softrst_ctrl;

    localparam logic [15:0] KEEP = 16'h001F;

    logic        clk = 1'b0;
    logic        phy_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phy_rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_q;
    logic [7:0]  irq_set = '0;
    logic [7:0]  irq_q;
    logic        mst_idle = 1'b1;
    logic        mst_stop;
    logic        core_rst;
    logic        phy_core_rst;
    logic        fs_rst;
    logic        rxflush;
    logic        sof = 1'b0;
    logic [10:0] frame_num;

    realtime phy_half = 8.5;
    int checks = 0;
    int errors = 0;
    int flush_hi = 0, fs_hi = 0, gphy_hi = 0, core_hi = 0;

    always #4 clk = ~clk;
    always #(phy_half) phy_clk = ~phy_clk;

    usb_softrst_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .phy_clk_i(phy_clk), .phy_rst_ni(phy_rst_n),
        .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_o(cfg_q),
        .irq_set_i(irq_set), .irq_o(irq_q),
        .mst_idle_i(mst_idle), .mst_stop_o(mst_stop), .core_rst_o(core_rst),
        .phy_core_rst_o(phy_core_rst), .fs_rst_o(fs_rst), .rxflush_o(rxflush),
        .sof_i(sof), .frame_num_o(frame_num)
    );

    always @(negedge phy_clk) begin
        if (rxflush)      flush_hi++;
        if (fs_rst)       fs_hi++;
        if (phy_core_rst) gphy_hi++;
    end
    always @(negedge clk) if (core_rst) core_hi++;

    function automatic logic [15:0] exp_cfg(logic [15:0] c, bit glb);
        return glb ? (c & KEEP) : c;
    endfunction

    function automatic real slow_per(real phy_per);
        return (phy_per > 8.0) ? phy_per : 8.0;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic cfg_wr(logic [15:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic irq_pulse(logic [7:0] d);
        @(negedge clk); irq_set = d;
        @(negedge clk); irq_set = '0;
    endtask

    task automatic sof_pulses(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge phy_clk); sof = 1'b1;
            @(negedge phy_clk); sof = 1'b0;
        end
    endtask

    task automatic wait_clear(logic [31:0] m, string req, output int cyc);
        cyc = 0;
        while (((reg_rdata & m) != 0) && (cyc < 4000)) begin
            @(negedge clk); cyc++;
        end
        chk(cyc < 4000, req, "request bit self-clear", reg_rdata, reg_rdata & ~m);
    endtask

    task automatic flush_test(realtime half);
        int cyc, f0;
        real per, lat, lo, hi;
        phy_half = half;
        repeat (10) @(negedge clk);
        per = 2.0 * half;
        f0 = flush_hi;
        reg_wr(32'h10);
        chk(reg_rdata[4] == 1'b1, "R9", "flush bit set", reg_rdata, 32'h10);
        wait_clear(32'h10, "R9", cyc);
        lat = 8.0 * cyc;
        lo = 8.0 * slow_per(per);
        hi = lo + 5.0 * per + 48.0;
        chk(lat >= lo, "R9", "flush latency lower bound ns", 32'(int'(lat)), 32'(int'(lo)));
        chk(lat <= hi, "R9", "flush latency upper bound ns", 32'(int'(lat)), 32'(int'(hi)));
        chk(flush_hi - f0 == 8, "R9", "flush high phy cycles", 32'(flush_hi - f0), 32'd8);
    endtask

    initial begin
        #1_500_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc, f0, g0, c0;
        logic [15:0] cfg_exp;
        logic [7:0]  irq_exp;
        logic [10:0] fr_exp;
        void'($urandom(32'd2024));

        #30;
        @(negedge clk); rst_n = 1'b1;
        @(negedge phy_clk); phy_rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // reset state
        chk(reg_rdata == 32'h8000_0000, "R3", "reset read value", reg_rdata, 32'h8000_0000);
        chk(cfg_q == 16'h0 && irq_q == 8'h0, "R5", "reset cfg/irq", {cfg_q, irq_q}, 32'h0);
        chk(frame_num == 11'd0, "R8", "reset frame number", 32'(frame_num), 32'd0);

        // R2 reserved bits and R1 zero writes
        reg_wr(32'h7FFF_FFE8);
        chk(reg_rdata == 32'h8000_0000, "R2", "reserved bits ignored", reg_rdata, 32'h8000_0000);
        reg_wr(32'h0);
        chk(reg_rdata == 32'h8000_0000, "R1", "zero write no effect", reg_rdata, 32'h8000_0000);

        // R3 idle status follows master
        mst_idle = 1'b0;
        @(negedge clk);
        chk(reg_rdata[31] == 1'b0, "R3", "idle bit low", 32'(reg_rdata[31]), 32'd0);
        mst_idle = 1'b1;
        @(negedge clk);
        chk(reg_rdata[31] == 1'b1, "R3", "idle bit high", 32'(reg_rdata[31]), 32'd1);

        // R7 engine reset
        f0 = fs_hi;
        reg_wr(32'h2);
        chk(reg_rdata[1] == 1'b1, "R1", "write-1 sets bit", 32'(reg_rdata[1]), 32'd1);
        wait_clear(32'h2, "R7", cyc);
        chk(fs_hi - f0 == 1, "R7", "engine reset pulse cycles", 32'(fs_hi - f0), 32'd1);

        // R8 frame counter
        sof_pulses(5);
        chk(frame_num == 11'd5, "R8", "frame increments", 32'(frame_num), 32'd5);
        reg_wr(32'h4);
        wait_clear(32'h4, "R8", cyc);
        chk(frame_num == 11'd0, "R8", "frame zero after reset", 32'(frame_num), 32'd0);
        sof_pulses(1);
        chk(frame_num == 11'd1, "R8", "frame after next sof", 32'(frame_num), 32'd1);

        // R9 flush with slower and faster PHY clock
        flush_test(8.5);
        flush_test(2.5);
        phy_half = 8.5;

        // R4 R5 R6 whole reset with busy master
        cfg_wr(16'hABCD);
        irq_pulse(8'h5A);
        sof_pulses(3);
        mst_idle = 1'b0;
        c0 = core_hi; g0 = gphy_hi;
        reg_wr(32'h1);
        repeat (20) @(negedge clk);
        chk(mst_stop == 1'b1, "R4", "stop held while master busy", 32'(mst_stop), 32'd1);
        chk(core_hi == c0, "R4", "no clear before idle", 32'(core_hi - c0), 32'd0);
        chk(reg_rdata[0] == 1'b1, "R6", "bit pending while draining", 32'(reg_rdata[0]), 32'd1);
        chk(cfg_q == 16'hABCD, "R5", "cfg intact before clear", 32'(cfg_q), 32'hABCD);
        mst_idle = 1'b1;
        wait_clear(32'h1, "R6", cyc);
        chk(mst_stop == 1'b0, "R4", "stop released", 32'(mst_stop), 32'd0);
        chk(core_hi - c0 == 1, "R4", "single clear pulse", 32'(core_hi - c0), 32'd1);
        chk(gphy_hi - g0 == 2, "R6", "phy reset pulse cycles", 32'(gphy_hi - g0), 32'd2);
        chk(cfg_q == exp_cfg(16'hABCD, 1'b1), "R5", "kept fields", 32'(cfg_q), 32'(exp_cfg(16'hABCD, 1'b1)));
        chk(irq_q == 8'h0, "R5", "irq cleared", 32'(irq_q), 32'd0);
        chk(frame_num == 11'd0, "R8", "frame zero after whole reset", 32'(frame_num), 32'd0);

        // R10 concurrent requests
        f0 = fs_hi; c0 = flush_hi;
        sof_pulses(2);
        reg_wr(32'h16);
        chk((reg_rdata & 32'h17) == 32'h16, "R10", "three bits set", reg_rdata & 32'h17, 32'h16);
        wait_clear(32'h16, "R10", cyc);
        chk(fs_hi - f0 == 1 && flush_hi - c0 == 8 && frame_num == 11'd0, "R10",
            "all actions done", {8'(fs_hi - f0), 8'(flush_hi - c0), 5'd0, frame_num}, {8'd1, 8'd8, 16'd0});

        // random mix
        cfg_exp = cfg_q; irq_exp = irq_q; fr_exp = frame_num;
        for (int it = 0; it < 16; it++) begin
            logic [31:0] r, m;
            logic [7:0]  iv;
            int n;
            r  = $urandom;
            iv = 8'($urandom);
            n  = $urandom_range(1, 6);
            cfg_wr(r[15:0]); cfg_exp = r[15:0];
            irq_pulse(iv);   irq_exp = irq_exp | iv;
            sof_pulses(n);   fr_exp = fr_exp + 11'(n);
            chk(frame_num == fr_exp, "R8", "random frame count", 32'(frame_num), 32'(fr_exp));
            m = {27'd0, r[18], 1'b0, r[17], r[16], (r[21:20] == 2'b00)};
            if (m == 0) m = 32'h2;
            f0 = fs_hi; c0 = flush_hi;
            reg_wr(m);
            wait_clear(m, "R10", cyc);
            if (m[0]) begin
                cfg_exp = exp_cfg(cfg_exp, 1'b1);
                irq_exp = '0;
            end
            if (m[0] || m[2]) fr_exp = '0;
            chk(cfg_q == cfg_exp, "R5", "random cfg", 32'(cfg_q), 32'(cfg_exp));
            chk(irq_q == irq_exp, "R5", "random irq", 32'(irq_q), 32'(irq_exp));
            chk(frame_num == fr_exp, "R8", "random frame after request", 32'(frame_num), 32'(fr_exp));
            chk(fs_hi - f0 == (m[1] ? 1 : 0), "R7", "random engine pulses", 32'(fs_hi - f0), 32'(m[1]));
            chk(flush_hi - c0 == (m[4] ? 8 : 0), "R9", "random flush cycles",
                32'(flush_hi - c0), (m[4] ? 32'd8 : 32'd0));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule